// File: doc/BRIEF.md
# USB Host Frame Interval Timer

This block paces a USB full-speed or low-speed host port. It counts PHY clock cycles and emits a pulse one cycle wide each time a frame interval has elapsed. With the speed-mode input low (full speed), the pulse marks the moment to issue a start-of-frame token. With it high (low speed), the pulse marks the moment to issue a keep-alive. The block does not form tokens, serialize packets or track frame numbers.

Software reaches the block through a small write port with two registers. The configuration register holds a 2-bit PHY clock select. The interval register holds a 16-bit cycle count, and its value can be read back on a 32-bit bus. Interval writes are taken only while the port-enable input is high; writes at any other time are dropped. Until an interval write has been taken, the timer uses a default count. The default is derived from the clock select: one millisecond of the selected PHY clock. A clock select that is reserved for the current speed mode stops the timer and raises an error flag.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset, `ivl_rdata` reads 0x0000EA60, `sof_pulse` is low and `clksel_err` is low. The clock select resets to code 01.
- R2: A write with `wr_sel`=1 loads `wr_data[15:0]` into the interval register. Bits 31:16 of `ivl_rdata` always read zero, and `wr_data[31:16]` is ignored.
- R3: An interval write while `port_en` is low is discarded. It changes neither `ivl_rdata` nor the interval the timer runs with.
- R4: Until an interval write has been accepted, the timer uses a default interval. Clock select code 01 (`wr_sel`=0, `wr_data[1:0]`) gives CNT_48M cycles (48000). Code 10 in low-speed mode gives CNT_6M cycles (6000).
- R5: Once an interval write is accepted, the timer runs with the programmed value instead of the default. Reset reverts the timer to the default.
- R6: In full-speed mode (`ls_mode`=0), any clock select other than 01 is reserved. In low-speed mode, codes 00 and 11 are reserved. A reserved code raises `clksel_err` and produces no pulses, even when an interval has been programmed.
- R7: The count is held at zero while `port_en` is low. The first pulse comes exactly N clock edges after the first edge at which `port_en` is sampled high, where N is the interval in use. Dropping `port_en` mid-frame restarts this.
- R8: `sof_pulse` is high for one cycle per frame, and consecutive pulses are exactly N cycles apart. With N=1 it is high every cycle.
- R9: An interval of zero produces no pulses and does not raise `clksel_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PHY clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clock select register, 1: interval register |
| wr_data | input | 32 | Write data |
| port_en | input | 1 | Host port enabled |
| ls_mode | input | 1 | 1: low-speed host, 0: full-speed host |
| sof_pulse | output | 1 | Frame-start pulse (start-of-frame token or keep-alive) |
| clksel_err | output | 1 | Clock select is reserved for the current mode |
| ivl_rdata | output | 32 | Interval register read-back |

## Verification
The bench sets the default counts to 40 for the 48 MHz code and 12 for the 6 MHz code. It keeps the interval register's 0xEA60 reset value. With these short defaults, the first-pulse timing and pulse spacing of every clock select and speed combination can be measured cycle-exactly in a short run. Programmed intervals of 1, 7 and 25 cover the single-cycle period and ordinary periods. An interval of 0 covers the stopped case.

// File: rtl/usb_ft_pkg.sv
package usb_ft_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    PHYSEL_RSV0 = 2'b00,
    PHYSEL_48M  = 2'b01,
    PHYSEL_6M   = 2'b10,
    PHYSEL_RSV3 = 2'b11
  } phy_sel_e;

  localparam logic REGSEL_CFG = 1'b0;
  localparam logic REGSEL_IVL = 1'b1;
endpackage

// File: rtl/usb_ft_regs.sv
module usb_ft_regs
  import usb_ft_pkg::*;
#(
  parameter int                DATA_W  = 32,
  parameter int                IVL_W   = 16,
  parameter logic [IVL_W-1:0]  RST_IVL = 16'hEA60
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              port_en,
  output phy_sel_e          clksel_o,
  output logic [IVL_W-1:0]  ivl_o,
  output logic              prog_o
);
  phy_sel_e           clksel_q;
  logic [IVL_W-1:0]   ivl_q;
  logic               prog_q;
  logic               ivl_wr_ok;

  assign ivl_wr_ok = wr_en && (wr_sel == REGSEL_IVL) && port_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      clksel_q <= PHYSEL_48M;
      ivl_q    <= RST_IVL;
      prog_q   <= 1'b0;
    end else begin
      if (wr_en && (wr_sel == REGSEL_CFG))
        clksel_q <= phy_sel_e'(wr_data[SEL_W-1:0]);
      if (ivl_wr_ok) begin
        ivl_q  <= wr_data[IVL_W-1:0];
        prog_q <= 1'b1;
      end
    end
  end

  assign clksel_o = clksel_q;
  assign ivl_o    = ivl_q;
  assign prog_o   = prog_q;

  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == REGSEL_IVL && !port_en) |=> ($stable(ivl_q) && $stable(prog_q)));

  // R5
  prog_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    prog_q |=> prog_q);
endmodule

// File: rtl/usb_ft_default.sv
module usb_ft_default
  import usb_ft_pkg::*;
#(
  parameter int IVL_W   = 16,
  parameter int CNT_48M = 48000,
  parameter int CNT_6M  = 6000
) (
  input  phy_sel_e          clksel_i,
  input  logic              ls_mode,
  output logic              cfg_ok_o,
  output logic [IVL_W-1:0]  def_ivl_o
);
  localparam logic [IVL_W-1:0] DEF48 = IVL_W'(CNT_48M);
  localparam logic [IVL_W-1:0] DEF6  = IVL_W'(CNT_6M);

  always_comb begin
    cfg_ok_o  = 1'b0;
    def_ivl_o = '0;
    unique case (clksel_i)
      PHYSEL_48M: begin
        cfg_ok_o  = 1'b1;
        def_ivl_o = DEF48;
      end
      PHYSEL_6M: begin
        cfg_ok_o  = ls_mode;
        def_ivl_o = ls_mode ? DEF6 : '0;
      end
      default: begin
        cfg_ok_o  = 1'b0;
        def_ivl_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/usb_ft_counter.sv
module usb_ft_counter #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             sof_o
);
  logic [IVL_W-1:0] cnt_q;
  logic [IVL_W-1:0] last;
  logic             sof_q;

  assign last = ivl_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      cnt_q <= '0;
      sof_q <= 1'b0;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      sof_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      sof_q <= 1'b0;
    end
  end

  assign sof_o = sof_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (cnt_q == '0 && !sof_q));

  // R7
  pulse_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    sof_q |-> $past(run_i));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (sof_q && run_i && ivl_i > 1) |=> !sof_q);
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import usb_ft_pkg::*;
#(
  parameter int               DATA_W  = 32,
  parameter int               IVL_W   = 16,
  parameter logic [IVL_W-1:0] RST_IVL = 16'hEA60,
  parameter int               CNT_48M = 48000,
  parameter int               CNT_6M  = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              port_en,
  input  logic              ls_mode,
  output logic              sof_pulse,
  output logic              clksel_err,
  output logic [DATA_W-1:0] ivl_rdata
);
  localparam int PAD_W = DATA_W - IVL_W;

  phy_sel_e          clksel;
  logic [IVL_W-1:0]  ivl_reg;
  logic              prog;
  logic              cfg_ok;
  logic [IVL_W-1:0]  def_ivl;
  logic [IVL_W-1:0]  eff_ivl;
  logic              run;
  logic              err_q;

  usb_ft_regs #(.DATA_W(DATA_W), .IVL_W(IVL_W), .RST_IVL(RST_IVL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .port_en(port_en), .clksel_o(clksel), .ivl_o(ivl_reg), .prog_o(prog)
  );

  usb_ft_default #(.IVL_W(IVL_W), .CNT_48M(CNT_48M), .CNT_6M(CNT_6M)) u_default (
    .clksel_i(clksel), .ls_mode(ls_mode), .cfg_ok_o(cfg_ok), .def_ivl_o(def_ivl)
  );

  assign eff_ivl = prog ? ivl_reg : def_ivl;
  assign run     = port_en && cfg_ok && (eff_ivl != '0);

  usb_ft_counter #(.IVL_W(IVL_W)) u_counter (
    .clk(clk), .rst(rst), .run_i(run), .ivl_i(eff_ivl), .sof_o(sof_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= !cfg_ok;
  end

  assign clksel_err = err_q;
  assign ivl_rdata  = {{PAD_W{1'b0}}, ivl_reg};

  // R6
  reserved_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_ok |=> (clksel_err && !sof_pulse));

  // R7
  pulse_port_chk: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> $past(port_en));
endmodule

// File: tb/usb_frame_timer_bench.sv
module usb_frame_timer_bench;
  localparam int D48 = 40;
  localparam int D6  = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        port_en = 1'b0;
  logic        ls_mode = 1'b0;
  logic        sof_pulse;
  logic        clksel_err;
  logic [31:0] ivl_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  usb_frame_timer #(.CNT_48M(D48), .CNT_6M(D6)) u_usb_frame_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .port_en(port_en), .ls_mode(ls_mode), .sof_pulse(sof_pulse),
    .clksel_err(clksel_err), .ivl_rdata(ivl_rdata)
  );

  // fields: [36] ls, [35:34] sel, [33] prog, [32:17] ivl, [16:1] period (0 = none), [0] err
  localparam logic [36:0] VEC [0:11] = '{
    {1'b0, 2'b01, 1'b0, 16'd0,  16'(D48), 1'b0},
    {1'b1, 2'b01, 1'b0, 16'd0,  16'(D48), 1'b0},
    {1'b1, 2'b10, 1'b0, 16'd0,  16'(D6),  1'b0},
    {1'b0, 2'b10, 1'b0, 16'd0,  16'd0,    1'b1},
    {1'b1, 2'b00, 1'b0, 16'd0,  16'd0,    1'b1},
    {1'b1, 2'b11, 1'b0, 16'd0,  16'd0,    1'b1},
    {1'b0, 2'b00, 1'b0, 16'd0,  16'd0,    1'b1},
    {1'b0, 2'b01, 1'b1, 16'd25, 16'd25,   1'b0},
    {1'b1, 2'b10, 1'b1, 16'd7,  16'd7,    1'b0},
    {1'b0, 2'b01, 1'b1, 16'd1,  16'd1,    1'b0},
    {1'b1, 2'b10, 1'b1, 16'd0,  16'd0,    1'b0},
    {1'b0, 2'b11, 1'b1, 16'd30, 16'd0,    1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; port_en = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // raise port_en at a negedge, return edges to first pulse and to the next
  task automatic measure(input int limit, output int first, output int gap);
    first = 0; gap = 0;
    port_en = 1'b1;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (sof_pulse) begin first = k; break; end
    end
    if (first != 0) begin
      for (int k = 1; k <= limit; k++) begin
        @(negedge clk);
        if (sof_pulse) begin gap = k; break; end
      end
    end
  endtask

  initial begin
    int f, g;
    ls_mode = 1'b0;
    do_reset();
    // R1 reset state
    check("R1 rdata", int'(ivl_rdata), 32'h0000EA60);
    check("R1 sof", int'(sof_pulse), 0);
    check("R1 err", int'(clksel_err), 0);

    // table walk: R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 12; i++) begin
      logic [36:0] v;
      v = VEC[i];
      do_reset();
      ls_mode = v[36];
      wr(1'b0, {30'd0, v[35:34]});
      if (v[33]) begin
        port_en = 1'b1;
        wr(1'b1, {16'd0, v[32:17]});
        port_en = 1'b0;
      end
      @(negedge clk); @(negedge clk);
      check($sformatf("R6 err vec %0d", i), int'(clksel_err), int'(v[0]));
      measure(3 * D48, f, g);
      check($sformatf("R7 first pulse vec %0d", i), f, int'(v[16:1]));
      check($sformatf("R8 spacing vec %0d", i), g, int'(v[16:1]));
      port_en = 1'b0;
    end

    // R3: write with port disabled is dropped
    do_reset();
    ls_mode = 1'b0;
    wr(1'b1, 32'h0000_0009);
    check("R3 rdata", int'(ivl_rdata), 32'h0000EA60);
    measure(3 * D48, f, g);
    check("R3 period stays default", f, D48);
    port_en = 1'b0;

    // R2: upper bits ignored
    @(negedge clk);
    port_en = 1'b1;
    wr(1'b1, 32'hABCD_0010);
    port_en = 1'b0;
    check("R2 rdata", int'(ivl_rdata), 32'h0000_0010);
    @(negedge clk);
    measure(3 * D48, f, g);
    check("R2 period", f, 16);

    // R7: drop port_en mid-frame restarts the full interval
    port_en = 1'b0;
    @(negedge clk);
    port_en = 1'b1;
    for (int k = 0; k < 9; k++) @(negedge clk);
    port_en = 1'b0;
    @(negedge clk);
    check("R7 held sof", int'(sof_pulse), 0);
    measure(3 * D48, f, g);
    check("R7 restart", f, 16);

    // R8: pulse width one cycle
    port_en = 1'b0;
    @(negedge clk);
    measure(3 * D48, f, g);
    @(negedge clk);
    check("R8 width", int'(sof_pulse), 0);
    port_en = 1'b0;

    // R5: reset reverts to default
    do_reset();
    check("R5 rdata after reset", int'(ivl_rdata), 32'h0000EA60);
    measure(3 * D48, f, g);
    check("R5 default after reset", f, D48);
    port_en = 1'b0;

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule